// File: doc/BRIEF.md
# RTC Periodic Interrupt and Square-Wave Generator

This block is the periodic-event section of a PC-style real-time clock. A free-running enable pulse at 32.768 kHz (`tick_32k`) feeds a divider whose period is picked by a 4-bit rate code held in the low nibble of control register A. Each time the period runs out, the block can latch interrupt flags in status register C and raise `irq`. It can also drive a square wave on `sqw`, or do both. Two enable bits in control register B select which of these outputs is active.

Software reaches the three registers through a plain byte-wide port: one write strobe and one read strobe, a 2-bit address, and write and read data buses. Read data is combinational from the address. Register C is read-to-clear, and its interrupt flag drives `irq` directly, so the handler acknowledges the interrupt by reading C. Any write to register A or register B restarts the divider, so a new rate takes effect from that cycle. No byte stream crosses this block's boundary, so the port has no valid/ready handshake and cannot stall. Every access completes in the cycle it is strobed.

Top module: `rtc_pulse_gen`

## Requirements
- R1: After reset, register A reads 0x26, register B reads 0x02, register C reads 0x00, and both `irq` and `sqw` are low.
- R2: Address 0 selects register A, address 1 register B and address 2 register C. Bytes written to A or B read back unchanged. Address 3 reads 0x00. Writes to address 2 or 3 leave every register unchanged.
- R3: When the rate code (register A bits 3:0) is 0, the divider is held at zero: `irq` never rises and `sqw` stays low.
- R4: Rate codes 1 and 2 act as codes 8 and 9, and every other code acts as itself. For an effective code n, the period is 2^(n-1) ticks, counted from the cycle after the last write to register A or B.
- R5: Only cycles with `tick_32k` high advance the divider.
- R6: When register B bit 6 (periodic interrupt enable) is set, each expiry sets register C bits 7 and 6, and `irq` follows register C bit 7.
- R7: When register B bit 3 (square-wave enable) is set, `sqw` is low for the first half of each period and high for the second half. `sqw` is low whenever that bit is clear.
- R8: With bit 6 clear, expiries leave register C at 0x00 and `irq` low, even while `sqw` runs. With both bit 6 and bit 3 clear, nothing happens at all.
- R9: Reading register C returns its current value. The register is cleared at that clock edge and `irq` drops, unless an expiry lands on the same edge, in which case the flags stay set.
- R10: A write to register A or B sets the divider count to zero and forces `sqw` low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz time base |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears register C when addressed) |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request, high while register C bit 7 is set |
| sqw | output | 1 | Square-wave output |

## Verification
The main sweep runs all fifteen nonzero rate codes with both enables set. It checks `irq` and `sqw` on every cycle across two full periods, reading C after the first expiry. This separates the remapped codes 1 and 2 from codes 8 and 9, and it would expose an off-by-one in the half-period or full-period compare. Short runs with only one enable set show whether the flag path and the square-wave path are gated independently. A run with the tick gapped two cycles in three separates tick counting from clock counting. A rewrite in the middle of a period shows whether the restart takes effect immediately or the old count carries on. Rate code 0 and the both-disabled case confirm that the divider stays idle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_NONE = 2'd3
  } rtc_sel_e;

  localparam logic [REG_W-1:0] RST_A = 8'h26;
  localparam logic [REG_W-1:0] RST_B = 8'h02;

  localparam int B_PIE  = 6;
  localparam int B_SQWE = 3;

  // Codes at or below this value are moved up by REMAP_ADD
  localparam int REMAP_MAX = 2;
  localparam int REMAP_ADD = 7;
endpackage

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 14
) (
  input  logic [CODE_W-1:0] code,
  output logic              nonzero,
  output logic [CNT_W-1:0]  period_m1,
  output logic [CNT_W-1:0]  half_m1
);
  import rtc_pkg::*;

  logic [CODE_W-1:0] eff;
  logic [CNT_W:0]    per_full;
  logic [CNT_W:0]    half_full;

  always_comb begin
    nonzero = (code != '0);
    if (nonzero && (code <= CODE_W'(REMAP_MAX)))
      eff = code + CODE_W'(REMAP_ADD);
    else
      eff = code;
    per_full  = '0;
    half_full = '0;
    if (eff >= CODE_W'(3)) begin
      per_full  = (CNT_W+1)'(1) << (eff - CODE_W'(1));
      half_full = (CNT_W+1)'(1) << (eff - CODE_W'(2));
    end
    period_m1 = CNT_W'(per_full - (CNT_W+1)'(1));
    half_m1   = CNT_W'(half_full - (CNT_W+1)'(1));
  end
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period_m1,
  input  logic [CNT_W-1:0] half_m1,
  output logic [CNT_W-1:0] cnt,
  output logic             phase,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  assign expire = run && tick && !restart && (cnt_q == period_m1);
  assign cnt    = cnt_q;
  assign phase  = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == period_m1) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == half_m1) phase_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              expire,
  output logic [7:0]        rdata,
  output logic [CODE_W-1:0] code,
  output logic              pie,
  output logic              sqwe,
  output logic              irq
);
  import rtc_pkg::*;

  logic [REG_W-1:0] reg_a_q;
  logic [REG_W-1:0] reg_b_q;
  logic [1:0]       flag_q;   // {IRQ flag, periodic flag}

  assign code = reg_a_q[CODE_W-1:0];
  assign pie  = reg_b_q[B_PIE];
  assign sqwe = reg_b_q[B_SQWE];
  assign irq  = flag_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a_q <= RST_A;
      reg_b_q <= RST_B;
    end else if (wr_en) begin
      if (addr == SEL_A) reg_a_q <= wdata;
      if (addr == SEL_B) reg_b_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 2'b00;
    else if (expire && pie)
      flag_q <= 2'b11;
    else if (rd_en && addr == SEL_C)
      flag_q <= 2'b00;
  end

  always_comb begin
    unique case (addr)
      SEL_A:   rdata = reg_a_q;
      SEL_B:   rdata = reg_b_q;
      SEL_C:   rdata = {flag_q, 6'b0};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_pulse_gen.sv
module rtc_pulse_gen #(
  parameter int CODE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sqw
);
  import rtc_pkg::*;

  localparam int CNT_W = (1 << CODE_W) - 2;

  logic [CODE_W-1:0] code;
  logic              pie, sqwe, nonzero, run, restart, phase, expire;
  logic [CNT_W-1:0]  period_m1, half_m1, div_cnt;

  assign restart = wr_en && (addr == SEL_A || addr == SEL_B);
  assign run     = nonzero && (pie || sqwe);
  assign sqw     = phase && sqwe && run;

  rtc_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .expire(expire), .rdata(rdata), .code(code), .pie(pie),
    .sqwe(sqwe), .irq(irq)
  );

  rtc_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .code(code), .nonzero(nonzero), .period_m1(period_m1), .half_m1(half_m1)
  );

  rtc_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .run(run), .restart(restart),
    .period_m1(period_m1), .half_m1(half_m1), .cnt(div_cnt), .phase(phase),
    .expire(expire)
  );
endmodule

// File: rtl/rtc_pulse_chk.sv
module rtc_pulse_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic              irq,
  input logic              sqw,
  input logic              expire,
  input logic              pie,
  input logic [CODE_W-1:0] code,
  input logic [CNT_W-1:0]  cnt
);
  // R9: a read of C with no coinciding expiry drops irq
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && !expire) |=> !irq);

  // R6: an expiry with interrupts enabled raises irq
  a_r6_expiry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && pie) |=> irq);

  // R8: irq cannot rise while the interrupt enable is clear
  a_r8_no_rise_without_pie: assert property (@(posedge clk) disable iff (!rst_n)
    !pie |=> !$rose(irq));

  // R3: rate code 0 keeps the divider silent
  a_r3_code0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> (!expire && !sqw));

  // R10: a write to A or B zeroes the count and the wave
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd0 || addr == 2'd1)) |=> (cnt == '0 && !sqw));
endmodule

bind rtc_pulse_gen rtc_pulse_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .irq(irq), .sqw(sqw), .expire(expire), .pie(pie), .code(code), .cnt(div_cnt)
);

// File: tb/rtc_pulse_gen_test.sv
`timescale 1ns/1ps
module rtc_pulse_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sqw;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rtc_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .sqw(sqw)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // Sweep one rate code over two periods; read C just after the first expiry
  task automatic run_rate(input int code, input bit pie, input bit sqwe);
    logic [7:0] d;
    int n, per, half;
    bit irq_exp, sqw_exp;
    n    = (code == 1 || code == 2) ? code + 7 : code;
    per  = 1 << (n - 1);
    half = per / 2;
    do_write(2'd0, 8'h00);
    do_read(2'd2, d);
    do_write(2'd1, 8'h02 | (8'(pie) << 6) | (8'(sqwe) << 3));
    do_write(2'd0, 8'(code));
    for (int i = 1; i <= 2 * per; i++) begin
      step();
      if (i == per + 1) rd_en = 1'b0;
      irq_exp = pie && (i == per || i >= 2 * per);
      sqw_exp = sqwe && ((i % per) >= half);
      check($sformatf("R4/R6 code %0d irq i=%0d", code, i), irq, irq_exp);
      check($sformatf("R4/R7 code %0d sqw i=%0d", code, i), sqw, sqw_exp);
      if (i == per) begin
        addr = 2'd2; rd_en = 1'b1;
        #1 check($sformatf("R9 R8 code %0d C read", code), rdata, pie ? 8'hC0 : 8'h00);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    check("R1 irq", irq, 0);
    check("R1 sqw", sqw, 0);
    do_read(2'd0, d); check("R1 reg A", d, 8'h26);
    do_read(2'd1, d); check("R1 reg B", d, 8'h02);
    do_read(2'd2, d); check("R1 reg C", d, 8'h00);

    // R2 register map
    do_read(2'd3, d); check("R2 addr 3", d, 8'h00);
    do_write(2'd0, 8'h5A); do_read(2'd0, d); check("R2 A readback", d, 8'h5A);
    do_write(2'd1, 8'h85); do_read(2'd1, d); check("R2 B readback", d, 8'h85);
    do_write(2'd2, 8'hFF); do_read(2'd2, d); check("R2 C write ignored", d, 8'h00);
    do_write(2'd3, 8'hFF);
    do_read(2'd0, d); check("R2 addr3 write A", d, 8'h5A);
    do_read(2'd1, d); check("R2 addr3 write B", d, 8'h85);

    // R4 R6 R7 sweep of all nonzero codes with both enables
    for (int c = 1; c < 16; c++) run_rate(c, 1'b1, 1'b1);
    // R8 interrupt-only and wave-only
    run_rate(3, 1'b1, 1'b0);
    run_rate(6, 1'b1, 1'b0);
    run_rate(3, 1'b0, 1'b1);
    run_rate(6, 1'b0, 1'b1);

    // R3 code 0 with both enables
    do_write(2'd0, 8'h00); do_read(2'd2, d);
    do_write(2'd1, 8'h4A);
    for (int i = 0; i < 40; i++) begin
      step();
      check("R3 irq idle", irq, 0);
      check("R3 sqw idle", sqw, 0);
    end
    // R8 both enables clear
    do_write(2'd1, 8'h02); do_write(2'd0, 8'h03);
    for (int i = 0; i < 20; i++) begin
      step();
      check("R8 irq disabled", irq, 0);
      check("R8 sqw disabled", sqw, 0);
    end
    do_read(2'd2, d); check("R8 C stays clear", d, 8'h00);

    // R10 restart mid-period: code 6, period 32, half 16
    do_write(2'd0, 8'h00); do_read(2'd2, d);
    do_write(2'd1, 8'h4A); do_write(2'd0, 8'h06);
    repeat (20) step();
    check("R10 sqw high before rewrite", sqw, 1);
    do_write(2'd0, 8'h06);
    check("R10 sqw low after rewrite", sqw, 0);
    for (int i = 1; i <= 32; i++) begin
      step();
      check($sformatf("R10 irq i=%0d", i), irq, i == 32);
    end

    // R5 tick gating: code 3 (4 ticks), one tick every third cycle
    do_write(2'd0, 8'h00); do_read(2'd2, d);
    do_write(2'd1, 8'h42);
    tick_32k = 1'b0;
    do_write(2'd0, 8'h03);
    for (int k = 1; k <= 12; k++) begin
      tick_32k = (k % 3 == 0);
      step();
      check($sformatf("R5 irq k=%0d", k), irq, k >= 12);
    end
    tick_32k = 1'b1;
    do_read(2'd2, d); check("R9 C after gated run", d, 8'hC0);
    check("R9 irq cleared", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule